// File: doc/BRIEF.md
# Programmable Event Timer with Timestamp

This peripheral gives software a way to schedule a single future event and to read a running time base. It holds two 32-bit counters that both advance on a shared tick-enable input. The event counter counts down from a value that software loads. The timestamp counts up without stopping. A one-byte control/status register starts and stops the event counter, selects automatic restart, and reports a sticky terminal-count flag. The interrupt output follows that flag.

Software stops the event counter, loads a count, and then sets the run bit again. When the count runs out, the flag is latched and the interrupt is raised. It stays high until software writes the control byte with the flag bit set. Because that same write may also set the run bit, one byte store both acknowledges the old event and arms the next one. Register access is single-cycle: a write takes effect at the clock edge where the strobe is sampled, and read data is registered and appears in the cycle after the read strobe.

Top module: `evtmr_top`

## Requirements
- R1: While `rst` is high, and after it is released, the event count, the timestamp and every control bit are zero and `irq_o` is low.
- R2: The read map is: the event count at address 0x00, the timestamp at 0x08, and the control byte at 0x14 in bits 7:0 with bits 31:8 zero. Read data is registered and is valid in the cycle after `bus_rd`. It shows the register values from before that edge. Any other address reads as zero.
- R3: The timestamp adds one on each cycle in which `tick_en` is high, wraps at 2^32, and ignores writes.
- R4: A write to 0x00 loads the event count and the restart value only while the run bit is clear. Each byte lane is written only if its bit of `bus_be` is set. While the run bit is set, such a write is ignored.
- R5: With the run bit (control bit 0) set, each tick lowers the event count by one. A tick when the count is 1 or 0 is an expiry, which sets the terminal-count flag (control bit 7).
- R6: When auto-restart is not selected, an expiry leaves the count at zero and clears the run bit.
- R7: When both the periodic bit (control bit 1) and the reload bit (control bit 2) are set, an expiry loads the last written count, leaves the run bit set, and still sets the flag.
- R8: The flag stays set until a control write (address 0x14 with `bus_be[0]` high) has bit 7 set. A control write with bit 7 clear leaves the flag unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R9: `irq_o` is high exactly while the terminal-count flag is set.
- R10: A single control write of 0x81 clears a pending flag and starts counting.
- R11: A control write sets bits 0, 1 and 2 to the written values. If it falls in the same cycle as an expiry, the written run bit takes priority over the self-clear of R6. Control bits 3 to 6 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-enable pulse shared by both counters |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, high while the terminal-count flag is set |

## Verification
The bench targets the following corner cases, each paired with what a wrong design would do:
- **Clear and expiry in the same cycle.** A design that lets the clear win would lose an event without any sign of it.
- **Count write while running.** A design that accepts it would corrupt an event already in progress.
- **Partial byte-lane count write.** A design that ignores the byte enables would change lanes that were not addressed.
- **Control write that leaves bit 7 clear.** A design that clears the flag on any control write would drop the interrupt early.
- **One-shot versus auto-restart expiry.** One-shot must stop at zero with the run bit clear. Auto-restart must reload the saved count and keep running.
- **Smallest supported count (15).** The expiry must come on exactly the fifteenth tick.

Random traffic, checked against a cycle model, mixes all of these with idle ticks and accesses to unmapped addresses.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  // Register byte offsets (software-visible map)
  localparam logic [7:0] OFS_COUNT = 8'h00;
  localparam logic [7:0] OFS_STAMP = 8'h08;
  localparam logic [7:0] OFS_CTRL  = 8'h14;

  // Control byte bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_PER  = 1;
  localparam int CB_RLD  = 2;
  localparam int CB_FLAG = 7;

  typedef struct packed {
    logic flag;
    logic rld;
    logic per;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    logic [7:0] b;
    b          = '0;
    b[CB_RUN]  = c.run;
    b[CB_PER]  = c.per;
    b[CB_RLD]  = c.rld;
    b[CB_FLAG] = c.flag;
    return b;
  endfunction

endpackage

// File: rtl/evtmr_regif.sv
module evtmr_regif
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  stamp_q,
  input  logic [7:0]        ctrl_byte,
  output logic              cnt_we,
  output logic              ctrl_we,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] A_COUNT = OFS_COUNT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STAMP = OFS_STAMP[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL  = OFS_CTRL[ADDR_W-1:0];

  logic              hit_count;
  logic              hit_stamp;
  logic              hit_ctrl;
  logic [DATA_W-1:0] rd_mux;

  assign hit_count = (bus_addr == A_COUNT);
  assign hit_stamp = (bus_addr == A_STAMP);
  assign hit_ctrl  = (bus_addr == A_CTRL);

  assign cnt_we  = bus_wr && hit_count && (|bus_be);
  assign ctrl_we = bus_wr && hit_ctrl && bus_be[0];

  always_comb begin
    rd_mux = '0;
    if (hit_count)      rd_mux = DATA_W'(cnt_q);
    else if (hit_stamp) rd_mux = DATA_W'(stamp_q);
    else if (hit_ctrl)  rd_mux = DATA_W'(ctrl_byte);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/evtmr_stamp.sv
module evtmr_stamp #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] stamp_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
    end else if (tick_en) begin
      stamp_q <= stamp_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/evtmr_downcnt.sv
module evtmr_downcnt
  import evtmr_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int BE_W = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             cnt_we,
  input  logic [BE_W-1:0]  cnt_be,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wbyte,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output ctrl_t            ctrl_q,
  output logic             expire
);

  logic [CNT_W-1:0] merged;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] reload_d;
  ctrl_t            ctrl_d;
  logic             step;
  logic             at_end;
  logic             auto_go;
  logic             load_ok;

  // Byte-lane merge of a count write with the present count
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign merged[g*8 +: 8] = cnt_be[g] ? cnt_wdata[g*8 +: 8] : cnt_q[g*8 +: 8];
  end

  assign step    = ctrl_q.run && tick_en;
  assign at_end  = (cnt_q <= CNT_W'(1));
  assign expire  = step && at_end;
  assign auto_go = ctrl_q.per && ctrl_q.rld;
  assign load_ok = cnt_we && !ctrl_q.run;

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    if (load_ok) begin
      cnt_d    = merged;
      reload_d = merged;
    end else if (expire) begin
      cnt_d = auto_go ? reload_q : '0;
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (expire && !auto_go) begin
      ctrl_d.run = 1'b0;
    end
    if (ctrl_we) begin
      ctrl_d.run = ctrl_wbyte[CB_RUN];
      ctrl_d.per = ctrl_wbyte[CB_PER];
      ctrl_d.rld = ctrl_wbyte[CB_RLD];
      if (ctrl_wbyte[CB_FLAG]) begin
        ctrl_d.flag = 1'b0;
      end
    end
    if (expire) begin
      ctrl_d.flag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
    end
  end

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic             cnt_we;
  logic             ctrl_we;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] stamp_q;
  ctrl_t            ctrl_q;
  logic             expire;
  logic [7:0]       ctrl_byte;

  assign ctrl_byte = ctrl_to_byte(ctrl_q);
  assign irq_o     = ctrl_q.flag;

  evtmr_regif #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) regif_i (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .cnt_q    (cnt_q),
    .stamp_q  (stamp_q),
    .ctrl_byte(ctrl_byte),
    .cnt_we   (cnt_we),
    .ctrl_we  (ctrl_we),
    .bus_rdata(bus_rdata)
  );

  evtmr_downcnt #(
    .CNT_W(CNT_W)
  ) downcnt_i (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .cnt_we    (cnt_we),
    .cnt_be    (bus_be),
    .cnt_wdata (CNT_W'(bus_wdata)),
    .ctrl_we   (ctrl_we),
    .ctrl_wbyte(bus_wdata[7:0]),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q),
    .ctrl_q    (ctrl_q),
    .expire    (expire)
  );

  evtmr_stamp #(
    .CNT_W(CNT_W)
  ) stamp_i (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .stamp_q(stamp_q)
  );

endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             ctrl_we,
  input logic [7:0]       ctrl_wbyte,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] stamp_q,
  input logic             run,
  input logic             per,
  input logic             rld,
  input logic             expire,
  input logic             irq_o
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_comb begin
    if (rst_q) begin
      reset_state_chk: assert (cnt_q == '0 && stamp_q == '0 && !run && !irq_o);
    end
  end

  // R3
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> stamp_q == $past(stamp_q) + CNT_W'(1));

  // R3
  stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(stamp_q));

  // R4
  run_count_lock_chk: assert property (@(posedge clk) disable iff (rst)
    run && !tick_en |=> $stable(cnt_q));

  // R5
  expire_irq_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq_o);

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    expire && !(per && rld) && !ctrl_we |=> !run && cnt_q == '0);

  // R7
  auto_reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire && per && rld && !ctrl_we |=> run && cnt_q == $past(reload_q));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o && !(ctrl_we && ctrl_wbyte[7]) |=> irq_o);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && ctrl_wbyte[7] && !expire |=> !irq_o);

endmodule

bind evtmr_top evtmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .ctrl_we   (ctrl_we),
  .ctrl_wbyte(bus_wdata[7:0]),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q),
  .stamp_q   (stamp_q),
  .run       (ctrl_q.run),
  .per       (ctrl_q.per),
  .rld       (ctrl_q.rld),
  .expire    (expire),
  .irq_o     (irq_o)
);

// File: tb/evtmr_tb.sv
module evtmr_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] m_cnt, m_rel, m_ts;
  logic        m_run, m_per, m_rld, m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  evtmr_top dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [7:0] m_ctrl();
    return {m_flag, 4'b0, m_rld, m_per, m_run};
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_cnt;
      5'h08:   return m_ts;
      5'h14:   return {24'h0, m_ctrl()};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_rel = '0; m_ts = '0;
    m_run = 0; m_per = 0; m_rld = 0; m_flag = 0;
  endtask

  // Advance the model by one clock with the given inputs
  task automatic model_step(input bit wr, input logic [4:0] a, input logic [3:0] be,
                            input logic [31:0] wd, input bit tk);
    bit fire, cwr, auto;
    logic [31:0] mg;
    fire = tk && m_run && (m_cnt <= 32'd1);
    cwr  = wr && (a == 5'h14) && be[0];
    auto = m_per && m_rld;
    for (int i = 0; i < 4; i++) mg[i*8 +: 8] = be[i] ? wd[i*8 +: 8] : m_cnt[i*8 +: 8];
    if (tk) m_ts = m_ts + 1;
    if (wr && a == 5'h00 && be != 0 && !m_run) begin
      m_cnt = mg; m_rel = mg;
    end else if (fire) begin
      m_cnt = auto ? m_rel : 32'h0;
    end else if (tk && m_run) begin
      m_cnt = m_cnt - 1;
    end
    if (fire && !auto) m_run = 0;
    if (cwr) begin
      m_run = wd[0]; m_per = wd[1]; m_rld = wd[2];
      if (wd[7]) m_flag = 0;
    end
    if (fire) m_flag = 1;
  endtask

  // One bus/clock cycle; returns read data observed after the edge
  task automatic cyc(input bit wr, input bit rd, input logic [4:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input bit tk, output logic [31:0] got);
    logic [31:0] exp_rd;
    string tag;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_be = be; bus_wdata = wd; tick_en = tk;
    exp_rd = m_read(a);
    model_step(wr, a, be, wd, tk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tick_en = 0;
    got = bus_rdata;
    chk({31'h0, irq_o}, {31'h0, m_flag}, "R9 irq follows flag");
    if (rd) begin
      case (a)
        5'h00:   tag = "R4 count read";
        5'h08:   tag = "R3 stamp read";
        5'h14:   tag = "R8 ctrl read";
        default: tag = "R2 unmapped read";
      endcase
      chk(got, exp_rd, tag);
    end
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    logic [31:0] g;
    cyc(1, 0, a, be, d, 0, g);
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d);
    cyc(0, 1, a, 4'h0, 32'h0, 0, d);
  endtask

  task automatic ticks(input int n);
    logic [31:0] g;
    for (int i = 0; i < n; i++) cyc(0, 0, 5'h0, 4'h0, 32'h0, 1, g);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] g;
    void'($urandom(32'hC0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk({31'h0, irq_o}, 32'h0, "R1 irq after reset");
    rd32(5'h00, d); chk(d, 32'h0, "R1 count zero");
    rd32(5'h14, d); chk(d, 32'h0, "R1 ctrl zero");

    // R2 unmapped and timestamp
    rd32(5'h1C, d); chk(d, 32'h0, "R2 unmapped reads zero");
    ticks(5);
    rd32(5'h08, d); chk(d, 32'd5, "R3 stamp after five ticks");
    wr32(5'h08, 32'hDEAD_BEEF);
    rd32(5'h08, d); chk(d, 32'd5, "R3 stamp write ignored");

    // R4 count load and byte lanes
    wr32(5'h00, 32'h1122_3344);
    wr32(5'h00, 32'hAA00_00BB, 4'b1001);
    rd32(5'h00, d); chk(d, 32'hAA22_33BB, "R4 byte-lane write");

    // R5/R6 minimum count one-shot
    wr32(5'h00, 32'h0000_000F);
    wr32(5'h14, 32'h01);
    ticks(14);
    chk({31'h0, irq_o}, 32'h0, "R5 no expiry before tick 15");
    rd32(5'h00, d); chk(d, 32'h1, "R5 count after 14 ticks");
    ticks(1);
    chk({31'h0, irq_o}, 32'h1, "R5 expiry on tick 15");
    rd32(5'h14, d); chk(d, 32'h80, "R6 run self-cleared, flag set");
    ticks(3);
    rd32(5'h00, d); chk(d, 32'h0, "R6 count stays zero");

    // R8 control write without bit 7
    wr32(5'h14, 32'h00);
    chk({31'h0, irq_o}, 32'h1, "R8 flag kept on bit7=0");

    // R4 write while running ignored; R10 0x81
    wr32(5'h00, 32'd40);
    wr32(5'h14, 32'h81);
    chk({31'h0, irq_o}, 32'h0, "R10 flag cleared by 0x81");
    rd32(5'h14, d); chk(d, 32'h01, "R10 running after 0x81");
    wr32(5'h00, 32'd7);
    rd32(5'h00, d); chk(d, 32'd40, "R4 write ignored while running");

    // R8/R11 clear coinciding with expiry
    wr32(5'h14, 32'h00);
    wr32(5'h00, 32'd2);
    wr32(5'h14, 32'h01);
    ticks(1);
    cyc(1, 0, 5'h14, 4'h1, 32'h81, 1, g);
    chk({31'h0, irq_o}, 32'h1, "R8 expiry beats clear");
    rd32(5'h14, d); chk(d, 32'h81, "R11 written run wins over self-clear");

    // R7 auto restart
    wr32(5'h14, 32'h80);
    wr32(5'h00, 32'd3);
    wr32(5'h14, 32'h87);
    ticks(3);
    chk({31'h0, irq_o}, 32'h1, "R7 flag on first expiry");
    rd32(5'h00, d); chk(d, 32'd3, "R7 reloaded count");
    wr32(5'h14, 32'h87);
    ticks(3);
    chk({31'h0, irq_o}, 32'h1, "R7 flag on second expiry");
    rd32(5'h14, d); chk(d, 32'h87, "R7 still running, R11 bits 3-6 zero");
    wr32(5'h14, 32'hFE);
    rd32(5'h14, d); chk(d, 32'h06, "R11 bits 3-6 read zero");

    // Random traffic checked against the model
    for (int n = 0; n < RAND_CYCLES; n++) begin
      int op;
      logic [4:0] a;
      logic [31:0] wd;
      bit tk;
      op = $urandom % 16;
      tk = ($urandom % 3) != 0;
      case ($urandom % 5)
        0: a = 5'h00; 1: a = 5'h08; 2: a = 5'h14; 3: a = 5'h04; default: a = 5'h1C;
      endcase
      if (op < 2) begin
        wd = $urandom % 48;
        cyc(1, 0, 5'h00, 4'($urandom), wd, tk, g);
      end else if (op < 4) begin
        wd = {24'h0, 8'($urandom)};
        if (op == 2) wd[0] = 1'b1;
        cyc(1, 0, 5'h14, 4'($urandom), wd, tk, g);
      end else if (op == 4) begin
        cyc(1, 0, a, 4'hF, $urandom, tk, g);
      end else begin
        cyc(0, 1, a, 4'h0, 32'h0, tk, g);
      end
    end

    // R1 reset again mid-activity
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    model_reset();
    chk({31'h0, irq_o}, 32'h0, "R1 irq low after reset");
    rd32(5'h08, d); chk(d, 32'h0, "R1 stamp cleared");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule